// File: doc/BRIEF.md
# Dual-Timebase Pulse Generator

This block drives one output pin with a repeating pulse train. Each period opens with an on phase and ends with an off phase. Two counters set the timing. The on-time counter measures how long the on phase lasts. The period counter measures the full repeat interval. Each counter has its own select bit, which makes it count either a fast strobe (nominally 1 ms) or a slow strobe (nominally 125 ms). Both strobes arrive already divided down, as single-cycle pulses in the system clock domain. An enable input and a polarity input decide where the train appears on the pin, and in which sense.

One tick combination is unsupported: a slow on-time with a fast period. The block reports it on an error output, and while it lasts the pin is held at the off level. The counts and the tick selects are sampled only when a period starts, so changes to them never cut a period short. Enable, polarity and the error check act on the pin at once. A chip normally places two instances of this block side by side.

Top module: `pulse_train_gen`

## Requirements
- R1: After a synchronous active-low reset, with enable clear, `pulse_o` equals `cfg_invert` (the off level) and `cfg_error_o` is low for a legal tick selection.
- R2: While `cfg_enable` is low, `pulse_o` stays constantly at the off level, which is low when `cfg_invert`=0 and high when `cfg_invert`=1.
- R3: The on level is high when `cfg_invert`=0 and low when `cfg_invert`=1. Polarity changes take effect in the same cycle.
- R4: `cfg_on_slow`=1 together with `cfg_prd_slow`=0 is illegal. While this holds, `cfg_error_o` is high in the same cycle and `pulse_o` is at the off level. Once the selection becomes legal, `cfg_error_o` goes low and the train restarts with the on phase.
- R5: A period starts in the on phase. The output leaves the on level after `cfg_on_count` on-timebase ticks and stays off until `cfg_prd_count` period-timebase ticks have elapsed. The next period then starts. A period count of 0 acts as 1.
- R6: If the latched on count is greater than or equal to the latched period count, the output stays at the on level for the whole period. If the on count is 0, the output never leaves the off level.
- R7: Select bit value 0 picks `tick_fast_i` and value 1 picks `tick_slow_i`. Each counter advances only on the strobe it selected and ignores the other one, including when both strobes arrive in the same cycle.
- R8: When enable rises (with a legal selection), the counters restart. `pulse_o` reaches the on level one clock after enable is first sampled high.
- R9: `cfg_on_count`, `cfg_prd_count`, `cfg_on_slow` and `cfg_prd_slow` are sampled only at a period start (enable rise or period expiry). Changes made in mid-period do not alter the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_fast_i | input | 1 | Fast timebase strobe, one cycle wide |
| tick_slow_i | input | 1 | Slow timebase strobe, one cycle wide |
| cfg_enable | input | 1 | Runs the pulse train |
| cfg_invert | input | 1 | Output polarity |
| cfg_on_slow | input | 1 | On-time counter uses the slow strobe |
| cfg_prd_slow | input | 1 | Period counter uses the slow strobe |
| cfg_on_count | input | CNT_W | On time in ticks |
| cfg_prd_count | input | CNT_W | Period in ticks |
| pulse_o | output | 1 | Pulse train output |
| cfg_error_o | output | 1 | Unsupported tick selection flag |

## Verification
The bench targets two kinds of coincidence. In the first, the two strobes arrive in the same cycle: the slow strobe is generated at an exact multiple of the fast strobe's spacing, so every slow tick lands on a fast tick. With mixed selections, each counter must then take only its own strobe. In the second, a configuration write lands on the cycle of a period expiry or of an enable edge. A reference model in the bench is updated on every rising edge and compared against both outputs on every falling edge, so it decides which of the two coincident events wins.

// File: rtl/pgen_pkg.sv
// Package: shared parameters and the latched configuration type for the
// pulse train generator. Assumes counts no wider than 16 bits.
package pgen_pkg;
    localparam int CNT_W = 8;

    typedef struct packed {
        logic [CNT_W-1:0] on_lim;
        logic [CNT_W-1:0] prd_lim;
        logic             on_slow;
        logic             prd_slow;
    } pgen_shadow_t;
endpackage

// File: rtl/pgen_tick_sel.sv
// Module: picks the fast or slow strobe for one counter.
// Assumes both strobes are single-cycle pulses in the clk domain.
module pgen_tick_sel (
    input  logic sel_slow,
    input  logic tick_fast,
    input  logic tick_slow,
    output logic tick_out
);
    // Purpose: pass only the selected strobe, drop the other.
    always_comb begin
        tick_out = sel_slow ? tick_slow : tick_fast;
    end
endmodule

// File: rtl/pgen_counter.sv
// Module: up counter with synchronous clear and advance strobe.
// Assumes clear has priority over advance; no wrap handling is needed
// because the caller bounds the count.
module pgen_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    output logic [W-1:0] count
);
    // Purpose: hold, clear or step the tick count.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (adv) count <= count + 1'b1;
    end
endmodule

// File: rtl/pulse_train_gen.sv
// Module: one pulse train channel with separate on-time and period
// timebases. Assumes tick strobes are single-cycle and synchronous to clk.
// Counts and tick selects are latched at each period start; enable,
// polarity and the illegal-selection check act combinationally.
module pulse_train_gen #(
    parameter int CNT_W = pgen_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_fast_i,
    input  logic             tick_slow_i,
    input  logic             cfg_enable,
    input  logic             cfg_invert,
    input  logic             cfg_on_slow,
    input  logic             cfg_prd_slow,
    input  logic [CNT_W-1:0] cfg_on_count,
    input  logic [CNT_W-1:0] cfg_prd_count,
    output logic             pulse_o,
    output logic             cfg_error_o
);
    localparam int EXT_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] on_lim;
        logic [CNT_W-1:0] prd_lim;
        logic             on_slow;
        logic             prd_slow;
    } shadow_t;

    shadow_t          sh_q;
    logic             run_q;
    logic             cfg_bad;
    logic             go;
    logic             on_tick;
    logic             prd_tick;
    logic             period_end;
    logic             reload;
    logic             cnt_clr;
    logic             on_adv;
    logic             full_on;
    logic             level_on;
    logic [CNT_W-1:0] on_cnt;
    logic [CNT_W-1:0] prd_cnt;

    // Purpose: flag the unsupported slow-on / fast-period selection.
    always_comb begin
        cfg_bad = cfg_on_slow & ~cfg_prd_slow;
        go      = cfg_enable & ~cfg_bad;
    end

    pgen_tick_sel u_on_sel (
        .sel_slow  (sh_q.on_slow),
        .tick_fast (tick_fast_i),
        .tick_slow (tick_slow_i),
        .tick_out  (on_tick)
    );

    pgen_tick_sel u_prd_sel (
        .sel_slow  (sh_q.prd_slow),
        .tick_fast (tick_fast_i),
        .tick_slow (tick_slow_i),
        .tick_out  (prd_tick)
    );

    // Purpose: detect period expiry; a zero limit behaves as one tick.
    always_comb begin
        period_end = run_q & prd_tick &
                     (({1'b0, prd_cnt} + EXT_W'(1)) >= {1'b0, sh_q.prd_lim});
        reload     = (go & ~run_q) | period_end;
        cnt_clr    = ~run_q | period_end;
        on_adv     = run_q & on_tick & (on_cnt < sh_q.on_lim);
    end

    // Purpose: track whether the train is running.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= go;
    end

    // Purpose: latch counts and tick selects at each period start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (reload) begin
            sh_q.on_lim   <= cfg_on_count;
            sh_q.prd_lim  <= cfg_prd_count;
            sh_q.on_slow  <= cfg_on_slow;
            sh_q.prd_slow <= cfg_prd_slow;
        end
    end

    pgen_counter #(.W(CNT_W)) u_on_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .adv   (on_adv),
        .count (on_cnt)
    );

    pgen_counter #(.W(CNT_W)) u_prd_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .adv   (run_q & prd_tick),
        .count (prd_cnt)
    );

    // Purpose: form the on level and apply polarity.
    always_comb begin
        full_on     = sh_q.on_lim >= sh_q.prd_lim;
        level_on    = go & run_q & (sh_q.on_lim != '0) &
                      (full_on | (on_cnt < sh_q.on_lim));
        pulse_o     = cfg_invert ^ level_on;
        cfg_error_o = cfg_bad;
    end
endmodule

// File: rtl/pulse_train_gen_chk.sv
// Checker: temporal properties of pulse_train_gen, attached by bind.
module pulse_train_gen_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_fast_i,
    input logic             tick_slow_i,
    input logic             cfg_enable,
    input logic             cfg_invert,
    input logic             pulse_o,
    input logic             cfg_error_o,
    input logic             run_q,
    input logic [CNT_W-1:0] on_cnt,
    input logic [CNT_W-1:0] on_lim,
    input logic [CNT_W-1:0] prd_cnt,
    input logic [CNT_W-1:0] prd_lim
);
    // R2: disabled output sits at the off level
    p_off_when_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |-> (pulse_o == cfg_invert));

    // R4: error flag forces the off level
    p_off_on_error_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error_o |-> (pulse_o == cfg_invert));

    // R5: on-time count never passes its latched limit
    p_on_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        on_cnt <= on_lim);

    // R5: period count stays below its limit (zero limit keeps it at zero)
    p_prd_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (prd_lim == '0) ? (prd_cnt == '0) : (prd_cnt < prd_lim));

    // R7: without any strobe a running train keeps its counts
    p_no_tick_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !tick_fast_i && !tick_slow_i) |=> ($stable(on_cnt) && $stable(prd_cnt)));

    // R8: counters sit at zero while the train is stopped
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && $past(!run_q)) |-> (on_cnt == '0 && prd_cnt == '0));
endmodule

bind pulse_train_gen pulse_train_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_fast_i (tick_fast_i),
    .tick_slow_i (tick_slow_i),
    .cfg_enable  (cfg_enable),
    .cfg_invert  (cfg_invert),
    .pulse_o     (pulse_o),
    .cfg_error_o (cfg_error_o),
    .run_q       (run_q),
    .on_cnt      (on_cnt),
    .on_lim      (sh_q.on_lim),
    .prd_cnt     (prd_cnt),
    .prd_lim     (sh_q.prd_lim)
);

// File: tb/pulse_train_gen_bench.sv
// Bench: behavioural reference model compared on every falling edge.
module pulse_train_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_fast_i = 1'b0;
    logic       tick_slow_i = 1'b0;
    logic       cfg_enable = 1'b0;
    logic       cfg_invert = 1'b0;
    logic       cfg_on_slow = 1'b0;
    logic       cfg_prd_slow = 1'b0;
    logic [7:0] cfg_on_count = 8'd0;
    logic [7:0] cfg_prd_count = 8'd0;
    logic       pulse_o;
    logic       cfg_error_o;

    int    n_tests = 0;
    int    n_fail = 0;
    int    cyc = 0;
    int    fast_gap = 3;
    int    slow_gap = 12;
    bit    comparing = 0;
    string cur_req = "R1";

    // reference model state
    bit m_run;
    int m_on, m_prd, m_on_lim, m_prd_lim;
    bit m_on_slow, m_prd_slow;

    pulse_train_gen u_pulse_train_gen (
        .clk(clk), .rst_n(rst_n), .tick_fast_i(tick_fast_i), .tick_slow_i(tick_slow_i),
        .cfg_enable(cfg_enable), .cfg_invert(cfg_invert), .cfg_on_slow(cfg_on_slow),
        .cfg_prd_slow(cfg_prd_slow), .cfg_on_count(cfg_on_count),
        .cfg_prd_count(cfg_prd_count), .pulse_o(pulse_o), .cfg_error_o(cfg_error_o)
    );

    always #2 clk = ~clk;

    // strobes: slow gap is a multiple of fast gap so they coincide
    always @(posedge clk) begin
        #1;
        cyc++;
        tick_fast_i = (cyc % fast_gap) == 0;
        tick_slow_i = (cyc % slow_gap) == 0;
    end

    function automatic bit legal_go();
        return cfg_enable && !(cfg_on_slow && !cfg_prd_slow);
    endfunction

    // model update on the edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_on = 0; m_prd = 0; m_on_lim = 0; m_prd_lim = 0;
            m_on_slow = 0; m_prd_slow = 0;
        end else begin
            bit g, ot, pt;
            g = legal_go();
            if (!m_run) begin
                m_on = 0; m_prd = 0;
                if (g) begin
                    m_on_lim = cfg_on_count; m_prd_lim = cfg_prd_count;
                    m_on_slow = cfg_on_slow; m_prd_slow = cfg_prd_slow;
                end
            end else begin
                ot = m_on_slow ? tick_slow_i : tick_fast_i;
                pt = m_prd_slow ? tick_slow_i : tick_fast_i;
                if (pt && (m_prd + 1 >= m_prd_lim)) begin
                    m_on = 0; m_prd = 0;
                    m_on_lim = cfg_on_count; m_prd_lim = cfg_prd_count;
                    m_on_slow = cfg_on_slow; m_prd_slow = cfg_prd_slow;
                end else begin
                    if (pt) m_prd++;
                    if (ot && m_on < m_on_lim) m_on++;
                end
            end
            m_run = g;
        end
    end

    task automatic check(string req, int act, int exp, string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // compare outputs on every falling edge
    always @(negedge clk) begin
        if (comparing) begin
            bit lvl;
            lvl = legal_go() && m_run && m_on_lim != 0 &&
                  (m_on_lim >= m_prd_lim || m_on < m_on_lim);
            check(cur_req, pulse_o, cfg_invert ^ lvl, "pulse_o");
            check(cur_req, cfg_error_o, cfg_on_slow && !cfg_prd_slow, "cfg_error_o");
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_cfg(bit en, bit inv, bit os, bit ps, int on, int prd);
        @(posedge clk); #1;
        cfg_enable = en; cfg_invert = inv; cfg_on_slow = os; cfg_prd_slow = ps;
        cfg_on_count = 8'(on); cfg_prd_count = 8'(prd);
    endtask

    // count cycles at the on level over a window, sampled mid-cycle
    task automatic count_on(int n, output int hits);
        hits = 0;
        repeat (n) begin
            @(negedge clk);
            if (pulse_o != cfg_invert) hits++;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        int hits;
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", pulse_o, 0, "pulse_o after reset");
        check("R1", cfg_error_o, 0, "error after reset");
        comparing = 1;

        // R2: disabled, both polarities, ticks running
        cur_req = "R2";
        set_cfg(0, 0, 0, 0, 2, 5); wait_cyc(30);
        set_cfg(0, 1, 0, 0, 2, 5); wait_cyc(30);

        // R8: enable rise -> on level one clock later
        cur_req = "R8";
        set_cfg(1, 0, 0, 0, 2, 5);
        @(negedge clk); check("R8", pulse_o, 0, "first enabled cycle");
        @(negedge clk); check("R8", pulse_o, 1, "one clock after enable");

        // R5: on 2 / period 5 fast ticks: 6 of 15 cycles on per period
        cur_req = "R5";
        wait_cyc(40);
        count_on(150, hits);
        check("R5", hits, 60, "on cycles over ten periods");

        // R3: inverted polarity
        cur_req = "R3";
        set_cfg(1, 1, 0, 0, 2, 5); wait_cyc(60);

        // R9: mid-period count change, also lands near boundaries
        cur_req = "R9";
        set_cfg(1, 0, 0, 0, 4, 7); wait_cyc(5);
        set_cfg(1, 0, 0, 0, 1, 3); wait_cyc(50);

        // R7: mixed timebases with coincident strobes
        cur_req = "R7";
        set_cfg(1, 0, 0, 1, 3, 2); wait_cyc(120);
        set_cfg(1, 0, 1, 1, 1, 3); wait_cyc(150);

        // R4: illegal selection
        cur_req = "R4";
        set_cfg(1, 0, 1, 0, 2, 5);
        @(negedge clk);
        check("R4", cfg_error_o, 1, "error flag raised");
        check("R4", pulse_o, 0, "off level on error");
        wait_cyc(30);
        set_cfg(1, 0, 0, 0, 2, 5);
        @(negedge clk);
        check("R4", cfg_error_o, 0, "error cleared");
        wait_cyc(40);

        // R6: on >= period, then zero on count
        cur_req = "R6";
        set_cfg(1, 0, 0, 0, 6, 4); wait_cyc(60);
        count_on(60, hits);
        check("R6", hits, 60, "full on when on>=period");
        set_cfg(1, 0, 0, 0, 0, 4); wait_cyc(30);
        count_on(60, hits);
        check("R6", hits, 0, "zero on count stays off");

        // R5: period count zero acts as one tick
        cur_req = "R5";
        set_cfg(1, 0, 0, 0, 1, 0); wait_cyc(60);

        // R8: toggle enable mid-period and restart
        cur_req = "R8";
        set_cfg(1, 0, 0, 0, 3, 6); wait_cyc(10);
        set_cfg(0, 0, 0, 0, 3, 6); wait_cyc(4);
        set_cfg(1, 0, 0, 0, 3, 6); wait_cyc(80);

        comparing = 0;
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule